// File: doc/BRIEF.md
# Three-Tier Nested Interrupt Controller

This block arbitrates twelve interrupt request lines for a small 8-bit processor core. Source 0 belongs to the power-supply monitor and sits alone in a top tier. Every other source is placed by software in either the high tier or the low tier. Three byte-wide configuration registers sit behind a simple write/read port and hold the global enable, the per-source enables and the per-source tier selections.

The controller presents one request at a time to the CPU as a strobe, together with a 4-bit source index and the tier of that source. It records which tiers are in service, so it knows when a handler is running. The CPU acknowledges the request, and this marks the tier of the presented source as in service. A return-from-interrupt pulse retires the innermost handler. A new request reaches the CPU only if its tier is strictly above every tier in service. As a result, the power monitor can preempt any handler, a high-tier source can preempt a low-tier handler, and no source can preempt a handler of its own tier.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Source 0 is the power-supply monitor. It is always enabled, always in tier 2 (top), and the global enable does not affect it. Sources 1 to 11 are never in tier 2.
- R2: Register address 0 is the enable register. Bit 7 is the global enable, and bits 6..0 enable sources 7..1 (bit k enables source k+1). It resets to 0x00.
- R3: Register address 1 is the tier register for sources 1..7. When bit k is 1, source k+1 is in tier 1 (high); when it is 0, that source is in tier 0 (low). Bit 7 always reads 0. It resets to 0x00.
- R4: Register address 2 is the secondary register. Bits 3..0 enable sources 8..11, and bits 7..4 set the tier of sources 8..11 (1 means high). It resets to 0xA0. Address 3 reads 0x00.
- R5: While the global enable is 0, no request from sources 1..11 reaches the CPU.
- R6: When eligible requests of different tiers are pending together, the highest tier wins. Within one tier, the lowest source index wins.
- R7: A request is presented only if its tier is strictly above the highest tier in service. Tier 2 preempts tier 1, tier 1 preempts tier 0, and a request never preempts its own tier.
- R8: `irq_req` rises on the clock edge after an eligible request is first sampled. From then until the acknowledge, `irq_req`, `irq_vec` and `irq_tier` stay unchanged, even when a higher request arrives.
- R9: An acknowledge while `irq_req` is high sets the in-service bit of the presented tier and drops `irq_req` on the same edge.
- R10: A return-from-interrupt pulse clears the highest set in-service bit.
- R11: `in_service` bit k is 1 while a tier k handler is in service. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | 12 | Level pending lines, bit i for source i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| irq_reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request strobe to the CPU |
| irq_vec | output | 4 | Index of the presented source |
| irq_tier | output | 2 | Tier of the presented source (0, 1, 2) |
| in_service | output | 3 | In-service flags, one per tier |

## Verification
A register write takes effect on its clock edge and can be read back in the following cycle. A pending line that is driven before an edge produces `irq_req`, with its vector and tier, right after that edge. Acknowledge and return pulses change `in_service` on the edge they span. After an acknowledge, a freshly eligible request appears one edge after the drop. The bench drives all inputs on the falling edge and samples one falling edge after the rising edge that should produce each result. Where a request must be absent, it checks over several cycles.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
    localparam int NUM_SRC  = 12;
    localparam int VEC_W    = $clog2(NUM_SRC);
    localparam int NUM_TIER = 3;
    localparam int TIER_W   = $clog2(NUM_TIER);
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    localparam logic [TIER_W-1:0] TIER_LOW  = 2'd0;
    localparam logic [TIER_W-1:0] TIER_HIGH = 2'd1;
    localparam logic [TIER_W-1:0] TIER_TOP  = 2'd2;

    localparam logic [ADDR_W-1:0] ADDR_EN  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PRI = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SEC = 2'd2;

    localparam logic [DATA_W-1:0] EN_RST  = 8'h00;
    localparam logic [DATA_W-1:0] PRI_RST = 8'h00;
    localparam logic [DATA_W-1:0] SEC_RST = 8'hA0;

    typedef struct packed {
        logic              req;
        logic [VEC_W-1:0]  vec;
        logic [TIER_W-1:0] tier;
    } present_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import nest_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_SRC-1:0] src_en,
    output logic [NUM_SRC-1:0] src_high
);
    localparam int BASE_CNT = 7;
    localparam int SEC_CNT  = NUM_SRC - 1 - BASE_CNT;

    typedef struct packed {
        logic [DATA_W-1:0]   en;
        logic [BASE_CNT-1:0] pri;
        logic [DATA_W-1:0]   sec;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                ADDR_EN:  cfg_d.en  = wdata;
                ADDR_PRI: cfg_d.pri = wdata[BASE_CNT-1:0];
                ADDR_SEC: cfg_d.sec = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en  <= EN_RST;
            cfg_q.pri <= PRI_RST[BASE_CNT-1:0];
            cfg_q.sec <= SEC_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_EN:  rdata = cfg_q.en;
            ADDR_PRI: rdata = {1'b0, cfg_q.pri};
            ADDR_SEC: rdata = cfg_q.sec;
            default:  rdata = '0;
        endcase
    end

    logic glb;
    assign glb = cfg_q.en[DATA_W-1];

    // Source 0 is the supply monitor: always enabled, never gated.
    assign src_en[0]   = 1'b1;
    assign src_high[0] = 1'b0;

    for (genvar i = 0; i < BASE_CNT; i++) begin : g_base
        assign src_en[i+1]   = glb & cfg_q.en[i];
        assign src_high[i+1] = cfg_q.pri[i];
    end

    for (genvar j = 0; j < SEC_CNT; j++) begin : g_sec
        assign src_en[BASE_CNT+1+j]   = glb & cfg_q.sec[j];
        assign src_high[BASE_CNT+1+j] = cfg_q.sec[SEC_CNT+j];
    end
endmodule

// File: rtl/irq_tier_pick.sv
module irq_tier_pick
    import nest_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_high,
    output logic               win_valid,
    output logic [VEC_W-1:0]   win_idx,
    output logic [TIER_W-1:0]  win_tier
);
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] tier_mask [NUM_TIER];
    logic [NUM_TIER-1:0] tier_any;
    logic [VEC_W-1:0]   tier_idx [NUM_TIER];

    assign elig = pend & src_en;

    always_comb begin
        tier_mask[TIER_TOP]  = '0;
        tier_mask[TIER_TOP][0] = elig[0];
        tier_mask[TIER_HIGH] = elig & src_high & ~NUM_SRC'(1);
        tier_mask[TIER_LOW]  = elig & ~src_high & ~NUM_SRC'(1);
    end

    // One lowest-index finder per tier.
    for (genvar t = 0; t < NUM_TIER; t++) begin : g_tier
        always_comb begin
            tier_any[t] = 1'b0;
            tier_idx[t] = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (tier_mask[t][i]) begin
                    tier_any[t] = 1'b1;
                    tier_idx[t] = VEC_W'(i);
                end
            end
        end
    end

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_tier  = TIER_LOW;
        for (int t = 0; t < NUM_TIER; t++) begin
            if (tier_any[t]) begin
                win_valid = 1'b1;
                win_idx   = tier_idx[t];
                win_tier  = TIER_W'(t);
            end
        end
    end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track
    import nest_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_fire,
    input  logic [TIER_W-1:0]   ack_tier,
    input  logic                reti,
    output logic [NUM_TIER-1:0] in_service,
    output logic [TIER_W:0]     active_lvl
);
    typedef struct packed {
        logic [NUM_TIER-1:0] isr;
    } track_t;

    track_t trk_d, trk_q;
    logic [NUM_TIER-1:0] after_ret;

    always_comb begin
        after_ret = trk_q.isr;
        if (reti) begin
            for (int t = 0; t < NUM_TIER; t++) begin
                if (trk_q.isr[t]) after_ret = trk_q.isr & ~(NUM_TIER'(1) << t);
            end
        end
        trk_d.isr = after_ret;
        if (ack_fire) trk_d.isr[ack_tier] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // 0 = idle, t+1 = tier t is the highest in service.
    always_comb begin
        active_lvl = '0;
        for (int t = 0; t < NUM_TIER; t++) begin
            if (trk_q.isr[t]) active_lvl = (TIER_W+1)'(t + 1);
        end
    end

    assign in_service = trk_q.isr;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nest_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        src_pend,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               irq_ack,
    input  logic               irq_reti,
    output logic               irq_req,
    output logic [3:0]         irq_vec,
    output logic [1:0]         irq_tier,
    output logic [2:0]         in_service
);
    logic [NUM_SRC-1:0] src_en, src_high;
    logic               win_valid;
    logic [VEC_W-1:0]   win_idx;
    logic [TIER_W-1:0]  win_tier;
    logic [TIER_W:0]    active_lvl;
    logic               ack_fire;

    present_t pr_d, pr_q;

    irq_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .src_en   (src_en),
        .src_high (src_high)
    );

    irq_tier_pick u_pick (
        .pend      (src_pend),
        .src_en    (src_en),
        .src_high  (src_high),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_tier  (win_tier)
    );

    assign ack_fire = irq_ack & pr_q.req;

    irq_nest_track u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_fire   (ack_fire),
        .ack_tier   (pr_q.tier),
        .reti       (irq_reti),
        .in_service (in_service),
        .active_lvl (active_lvl)
    );

    always_comb begin
        pr_d = pr_q;
        if (pr_q.req) begin
            if (irq_ack) pr_d.req = 1'b0;
        end else if (win_valid && ({1'b0, win_tier} + 1'b1 > active_lvl)) begin
            pr_d.req  = 1'b1;
            pr_d.vec  = win_idx;
            pr_d.tier = win_tier;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign irq_req  = pr_q.req;
    assign irq_vec  = pr_q.vec;
    assign irq_tier = pr_q.tier;
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_req,
    input logic [3:0] irq_vec,
    input logic [1:0] irq_tier,
    input logic       irq_ack,
    input logic       irq_reti,
    input logic [2:0] in_service
);
    logic [2:0] top_lvl;
    always_comb begin
        top_lvl = 3'd0;
        for (int t = 0; t < 3; t++) if (in_service[t]) top_lvl = 3'(t + 1);
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req && $stable(irq_vec) && $stable(irq_tier));

    assert_top_only_src0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((irq_tier == 2'd2) == (irq_vec == 4'd0)));

    assert_above_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ({1'b0, irq_tier} + 3'd1 > top_lvl));

    assert_ack_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack && irq_tier == 2'd1 |=> !irq_req && in_service[1]);

    assert_ret_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_reti && !irq_ack && in_service[2] |=> !in_service[2]);

    assert_ret_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_reti && !irq_ack && in_service[2:1] == 2'b01
        |=> !in_service[1] && in_service[0] == $past(in_service[0]));
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .irq_tier   (irq_tier),
    .irq_ack    (irq_ack),
    .irq_reti   (irq_reti),
    .in_service (in_service)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [11:0] src_pend = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_reti = 1'b0;
    logic       irq_req;
    logic [3:0] irq_vec;
    logic [1:0] irq_tier;
    logic [2:0] in_service;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_reti(irq_reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_tier(irq_tier),
        .in_service(in_service)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1; cycle(); irq_ack = 1'b0;
    endtask

    task automatic reti();
        irq_reti = 1'b1; cycle(); irq_reti = 1'b0;
    endtask

    task automatic drain();
        src_pend = '0;
        if (irq_req) ack();
        repeat (3) reti();
        cycle();
    endtask

    task automatic expect_req(input string r, input logic [3:0] v, input logic [1:0] t);
        check({r, " req"}, irq_req, 1'b1);
        check({r, " vec"}, irq_vec, v);
        check({r, " tier"}, irq_tier, t);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R11 reset in_service", in_service, 3'b000);
        check("R8 reset req", irq_req, 1'b0);
        rd(2'd0, d); check("R2 enable reset", d, 8'h00);
        rd(2'd1, d); check("R3 tier reset", d, 8'h00);
        rd(2'd2, d); check("R4 secondary reset", d, 8'hA0);
        rd(2'd3, d); check("R4 addr3 reads 0", d, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); check("R3 bit7 reads 0", d, 8'h7F);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_global();
        wr(2'd0, 8'h7F);
        src_pend = 12'h0FE;
        repeat (3) begin
            cycle();
            check("R5 global off blocks", irq_req, 1'b0);
        end
        src_pend = 12'h001;
        cycle();
        expect_req("R1 monitor ungated", 4'd0, 2'd2);
        drain();
    endtask

    task automatic t_ties();
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h10);
        src_pend = 12'h018;
        cycle();
        expect_req("R6 same tier lowest index", 4'd3, 2'd0);
        drain();
        src_pend = 12'h028;
        cycle();
        expect_req("R6 higher tier wins", 4'd5, 2'd1);
        drain();
        src_pend = 12'h029;
        cycle();
        expect_req("R6 top tier wins", 4'd0, 2'd2);
        drain();
    endtask

    task automatic t_nest();
        src_pend = 12'h008;
        cycle();
        expect_req("R8 one edge latency", 4'd3, 2'd0);
        ack();
        check("R9 ack low", in_service, 3'b001);
        check("R9 req drops", irq_req, 1'b0);
        src_pend = 12'h018;
        repeat (3) begin
            cycle();
            check("R7 equal tier no preempt", irq_req, 1'b0);
        end
        src_pend = 12'h038;
        cycle();
        expect_req("R7 high preempts low", 4'd5, 2'd1);
        ack();
        check("R9 ack high", in_service, 3'b011);
        src_pend = 12'h039;
        cycle();
        expect_req("R7 top preempts high", 4'd0, 2'd2);
        ack();
        check("R11 all in service", in_service, 3'b111);
        src_pend = '0;
        reti();
        check("R10 reti top", in_service, 3'b011);
        reti();
        check("R10 reti high", in_service, 3'b001);
        reti();
        check("R10 reti low", in_service, 3'b000);
        cycle();
    endtask

    task automatic t_hold();
        src_pend = 12'h008;
        cycle();
        expect_req("R8 present", 4'd3, 2'd0);
        src_pend = 12'h009;
        repeat (3) begin
            cycle();
            expect_req("R8 held until ack", 4'd3, 2'd0);
        end
        ack();
        check("R9 drop after ack", irq_req, 1'b0);
        cycle();
        expect_req("R7 monitor after ack", 4'd0, 2'd2);
        drain();
    endtask

    task automatic t_secondary();
        wr(2'd2, 8'h0F);
        src_pend = 12'h900;
        cycle();
        expect_req("R4 sec low lowest index", 4'd8, 2'd0);
        drain();
        wr(2'd2, 8'h8F);
        src_pend = 12'h900;
        cycle();
        expect_req("R4 sec tier bit", 4'd11, 2'd1);
        drain();
        wr(2'd2, 8'h07);
        src_pend = 12'h800;
        repeat (2) begin
            cycle();
            check("R4 sec enable bit", irq_req, 1'b0);
        end
        drain();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global();
        t_ties();
        t_nest();
        t_hold();
        t_secondary();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule